// File: doc/BRIEF.md
# Accumulator Addressing-Mode Sequencer

This block is the execution engine of a one-address accumulator machine. A host presents one instruction at a time on `start_i` together with an operation, an addressing mode, a register selector and a constant. The block works out where the operand lives, runs zero, one or two data reads on a single-port synchronous memory port, and then updates the accumulator, the carry, the address register or one of the general registers. `busy_o` is high while it works, and `done_o` marks the last cycle of each instruction.

The operation and the mode are independent fields, so every operation can use every mode. The exceptions are listed below and are reported through `illegal_o`. The number of memory cycles depends only on the mode, so a sequencer chains the accesses. Its states are: `S_IDLE` (waiting; `accept` on start), `S_PTR` (pointer read, indirect mode only), `S_OPND` (operand read), `S_STORE` (accumulator write), `S_EXEC` (ALU or register move) and `S_FIN` (the done cycle). The transitions are:

- `accept`: `S_IDLE` goes to `S_EXEC` for an immediate operand or a move, to `S_PTR` for indirect mode, to `S_STORE` for a save, to `S_OPND` otherwise, and straight to `S_FIN` when the combination is illegal.
- `ptr_ok`: `S_PTR` goes to `S_STORE` or `S_OPND`.
- `opnd_ok`: `S_OPND` goes to `S_EXEC`.
- `store_ok`: `S_STORE` goes to `S_FIN`.
- `exec`: `S_EXEC` goes to `S_FIN`.
- `retire`: `S_FIN` goes to `S_IDLE`.

Each memory state waits in place until the port reports ready.

Top module: `acc_mode_seq`

## Requirements
- R1: After reset the accumulator, carry, address register and all general registers are zero, and `busy_o`, `done_o`, `illegal_o` and `mem_req_o` are low.
- R2: `start_i` is taken only while `busy_o` is low. `busy_o` stays high from the cycle after acceptance up to and including the single cycle in which `done_o` is high. A start raised while busy is ignored.
- R3: Mode 0 (immediate) uses the constant itself as the operand and makes no memory access.
- R4: Mode 1 (direct) reads memory once, at the constant.
- R5: Mode 2 (memory indirect) first reads at the constant, then uses the returned word as the address of the operand read.
- R6: Mode 3 (register direct) reads once, at the address held in general register `rsel_i`.
- R7: Mode 4 (displacement) reads at address register plus constant and leaves the address register unchanged.
- R8: Mode 5 (index) reads at address register plus general register `rsel_i` and leaves the address register unchanged.
- R9: Mode 6 (autoindex) addresses memory like mode 5, then sets the address register to its old value plus one. The next instruction sees the new value.
- R10: Operation 0 (LOAD) copies the operand into the accumulator. Operation 1 (ADD) adds the operand modulo 2^DW and sets the carry to the carry-out. Every other operation leaves the carry unchanged.
- R11: Operation 2 (SAVE) writes the accumulator to the effective address of modes 1 to 6. In mode 2 the write follows the pointer read.
- R12: SAVE with mode 0, any operation with mode 7, and operation 3 with a mode above 1 are illegal. For these, `illegal_o` is high in the done cycle, there is no memory access, and no register changes.
- R13: Operation 3 (MOVE) with mode 0 copies the accumulator into general register `rsel_i`. With mode 1 it copies the accumulator into the address register. Neither makes a memory access.
- R14: A memory request keeps its address, write flag and write data stable until it is accepted at a clock edge where `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the presented instruction |
| op_i | input | 2 | Operation: 0 LOAD, 1 ADD, 2 SAVE, 3 MOVE |
| mode_i | input | 3 | Addressing mode 0..6, 7 reserved |
| rsel_i | input | RSW | General register selector |
| const_i | input | DW | Instruction constant |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Last cycle of an instruction |
| illegal_o | output | 1 | Retired instruction was illegal |
| acc_o | output | DW | Accumulator |
| carry_o | output | 1 | Carry from the last ADD |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | DW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ready |
| mem_ready_i | input | 1 | Request accepted at this edge |

## Verification
The address register and the general registers are not visible at the ports. If either holds a wrong value, the `mem_addr_o` of the next register-based access is wrong, and that access can come as soon as the first memory cycle of the following instruction. A wrong latched mode shows up as an extra or missing memory handshake before `done_o`. A wrong accumulator or carry shows up in the done cycle. The bench compares the sequence of accesses and the retired results of every instruction against a behavioural model, and it compares the idle outputs on every clock.

// File: rtl/acc_mode_pkg.sv
package acc_mode_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SAVE = 2'd2,
        OP_MOVE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_DIR  = 3'd1,
        M_IND  = 3'd2,
        M_REG  = 3'd3,
        M_DISP = 3'd4,
        M_IDX  = 3'd5,
        M_AUTO = 3'd6,
        M_RSV  = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PTR   = 3'd1,
        S_OPND  = 3'd2,
        S_STORE = 3'd3,
        S_EXEC  = 3'd4,
        S_FIN   = 3'd5
    } state_e;

endpackage

// File: rtl/acc_mode_regs.sv
module acc_mode_regs #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int RSW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RSW-1:0] rd_sel,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [RSW-1:0] wr_sel,
    input  logic [DW-1:0]  wr_data,
    input  logic           ar_we,
    input  logic [DW-1:0]  ar_wdata,
    output logic [DW-1:0]  ar_q
);
    logic [DW-1:0] gpr [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) gpr[i] <= '0;
            ar_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_en && (wr_sel == RSW'(i))) gpr[i] <= wr_data;
            end
            if (ar_we) ar_q <= ar_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_sel == RSW'(i)) rd_data = gpr[i];
        end
    end
endmodule

// File: rtl/acc_mode_agu.sv
module acc_mode_agu
    import acc_mode_pkg::*;
#(
    parameter int DW = 16
) (
    input  mode_e         mode,
    input  logic [DW-1:0] cval,
    input  logic [DW-1:0] ar,
    input  logic [DW-1:0] rval,
    output logic [DW-1:0] ea
);
    always_comb begin
        unique case (mode)
            M_REG:          ea = rval;
            M_DISP:         ea = ar + cval;
            M_IDX, M_AUTO:  ea = ar + rval;
            default:        ea = cval;
        endcase
    end
endmodule

// File: rtl/acc_mode_alu.sv
module acc_mode_alu
    import acc_mode_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] acc,
    input  logic          carry,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] acc_n,
    output logic          carry_n
);
    always_comb begin
        acc_n   = acc;
        carry_n = carry;
        unique case (op)
            OP_LOAD: acc_n = opnd;
            OP_ADD:  {carry_n, acc_n} = {1'b0, acc} + {1'b0, opnd};
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_mode_seq.sv
module acc_mode_seq
    import acc_mode_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int RSW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [1:0]     op_i,
    input  logic [2:0]     mode_i,
    input  logic [RSW-1:0] rsel_i,
    input  logic [DW-1:0]  const_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           illegal_o,
    output logic [DW-1:0]  acc_o,
    output logic           carry_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [DW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i
);
    state_e         st, st_n;
    op_e            op_q, op_c;
    mode_e          mode_q, mode_c;
    logic [RSW-1:0] rsel_q;
    logic [DW-1:0]  ea_q, ea_c, opnd_q, acc_q, acc_n, ar_q, ar_wd, rval;
    logic           carry_q, carry_n, ill_q, ill_c, accept, hs;
    logic           gpr_we, ar_we;

    assign op_c   = op_e'(op_i);
    assign mode_c = mode_e'(mode_i);
    assign accept = start_i && (st == S_IDLE);
    assign hs     = mem_req_o && mem_ready_i;
    assign ill_c  = (mode_c == M_RSV)
                 || (op_c == OP_SAVE && mode_c == M_IMM)
                 || (op_c == OP_MOVE && mode_c != M_IMM && mode_c != M_DIR);

    acc_mode_regs #(.DW(DW), .NREG(NREG), .RSW(RSW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rsel_i),
        .rd_data  (rval),
        .wr_en    (gpr_we),
        .wr_sel   (rsel_q),
        .wr_data  (acc_q),
        .ar_we    (ar_we),
        .ar_wdata (ar_wd),
        .ar_q     (ar_q)
    );

    acc_mode_agu #(.DW(DW)) u_agu (
        .mode (mode_c),
        .cval (const_i),
        .ar   (ar_q),
        .rval (rval),
        .ea   (ea_c)
    );

    acc_mode_alu #(.DW(DW)) u_alu (
        .op      (op_q),
        .acc     (acc_q),
        .carry   (carry_q),
        .opnd    (opnd_q),
        .acc_n   (acc_n),
        .carry_n (carry_n)
    );

    // Register-file and address-register write controls
    assign gpr_we = (st == S_EXEC) && (op_q == OP_MOVE) && (mode_q == M_IMM);
    assign ar_we  = ((st == S_EXEC) && (op_q == OP_MOVE) && (mode_q == M_DIR))
                 || ((mode_q == M_AUTO) && hs && (st == S_OPND || st == S_STORE));
    assign ar_wd  = (op_q == OP_MOVE) ? acc_q : ar_q + DW'(1);

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (accept) begin
                    if (ill_c)                                      st_n = S_FIN;
                    else if (op_c == OP_MOVE || mode_c == M_IMM)    st_n = S_EXEC;
                    else if (mode_c == M_IND)                       st_n = S_PTR;
                    else if (op_c == OP_SAVE)                       st_n = S_STORE;
                    else                                            st_n = S_OPND;
                end
            end
            S_PTR:   if (mem_ready_i) st_n = (op_q == OP_SAVE) ? S_STORE : S_OPND;
            S_OPND:  if (mem_ready_i) st_n = S_EXEC;
            S_STORE: if (mem_ready_i) st_n = S_FIN;
            S_EXEC:  st_n = S_FIN;
            S_FIN:   st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            mode_q  <= M_IMM;
            rsel_q  <= '0;
            ill_q   <= 1'b0;
            ea_q    <= '0;
            opnd_q  <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= op_c;
                mode_q <= mode_c;
                rsel_q <= rsel_i;
                ill_q  <= ill_c;
                ea_q   <= ea_c;
                opnd_q <= const_i;
            end
            if (st == S_PTR && mem_ready_i)  ea_q   <= mem_rdata_i;
            if (st == S_OPND && mem_ready_i) opnd_q <= mem_rdata_i;
            if (st == S_EXEC) begin
                acc_q   <= acc_n;
                carry_q <= carry_n;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (st != S_IDLE);
        done_o      = (st == S_FIN);
        illegal_o   = (st == S_FIN) && ill_q;
        mem_req_o   = (st == S_PTR) || (st == S_OPND) || (st == S_STORE);
        mem_we_o    = (st == S_STORE);
        mem_addr_o  = ea_q;
        mem_wdata_o = acc_q;
        acc_o       = acc_q;
        carry_o     = carry_q;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R14
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3
    imm_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mode_q == M_IMM) |-> !mem_req_o);

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!mem_req_o && $stable(acc_o) && $stable(carry_o)));

    // R7
    ar_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (mode_q == M_DISP || mode_q == M_IDX)) |=> $stable(ar_q));

    // R9
    auto_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == M_AUTO) && hs && (st == S_OPND || st == S_STORE)) |=>
            (ar_q == $past(ar_q) + DW'(1)));
endmodule

// File: tb/acc_mode_seq_bench.sv
module acc_mode_seq_bench;
    localparam int DW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  md = '0;
    logic [1:0]  rs = '0;
    logic [15:0] cv = '0;
    logic        busy_o, done_o, illegal_o, carry_o, mem_req_o, mem_we_o;
    logic [15:0] acc_o, mem_addr_o, mem_wdata_o;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #10 clk = ~clk;

    acc_mode_seq #(.DW(DW), .NREG(4)) u_acc_mode_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .mode_i(md),
        .rsel_i(rs), .const_i(cv), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .acc_o(acc_o), .carry_o(carry_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
    );

    int nchk = 0, nfail = 0, ndone = 0, lat = 0, wcnt = 0;
    logic [15:0] mem [256];
    logic [15:0] m_acc = '0, m_ar = '0;
    logic        m_carry = 1'b0;
    logic [15:0] m_regs [4];
    logic [15:0] obs_addr[$], exp_addr[$], obs_wd[$], exp_wd[$];
    logic        obs_we[$], exp_we[$];
    logic [15:0] cap_addr, cap_wd;
    logic        cap_we, prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder with programmable wait
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else begin
            if (mem_ready) begin
                obs_addr.push_back(cap_addr);
                obs_we.push_back(cap_we);
                obs_wd.push_back(cap_wd);
                if (cap_we) mem[cap_addr[7:0]] = cap_wd;
                mem_ready = 1'b0;
                wcnt = 0;
            end
            if (mem_req_o && !mem_ready) begin
                if (wcnt >= lat) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem[mem_addr_o[7:0]];
                    cap_addr  = mem_addr_o;
                    cap_we    = mem_we_o;
                    cap_wd    = mem_wdata_o;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) ndone++;
            if (done_o && prev_done) chk(1'b0, "R2", "done wider than one cycle", 1, 0);
            prev_done = done_o;
            if (!busy_o) begin
                chk(acc_o == m_acc, "R10", "idle accumulator", acc_o, m_acc);
                chk(carry_o == m_carry, "R10", "idle carry", carry_o, m_carry);
            end
        end
    end

    task automatic run(input logic [1:0] iop, input logic [2:0] imd, input logic [1:0] irs,
                       input logic [15:0] icv, input string req, input bit poke = 1'b0);
        logic        ill;
        logic [15:0] ea, opnd, e_acc, e_ar;
        logic        e_carry;
        logic [15:0] e_regs [4];
        int          n, d0;
        e_acc = m_acc; e_carry = m_carry; e_ar = m_ar;
        for (int i = 0; i < 4; i++) e_regs[i] = m_regs[i];
        exp_addr.delete(); exp_we.delete(); exp_wd.delete();
        obs_addr.delete(); obs_we.delete(); obs_wd.delete();
        ill = (imd == 3'd7) || (iop == 2'd2 && imd == 3'd0) || (iop == 2'd3 && imd > 3'd1);
        opnd = icv;
        if (!ill) begin
            if (iop == 2'd3) begin
                if (imd == 3'd0) e_regs[irs] = m_acc; else e_ar = m_acc;
            end else begin
                case (imd)
                    3'd2: begin
                        exp_addr.push_back(icv); exp_we.push_back(1'b0); exp_wd.push_back('0);
                        ea = mem[icv[7:0]];
                    end
                    3'd3:    ea = m_regs[irs];
                    3'd4:    ea = m_ar + icv;
                    3'd5, 3'd6: ea = m_ar + m_regs[irs];
                    default: ea = icv;
                endcase
                if (imd != 3'd0) begin
                    exp_addr.push_back(ea);
                    exp_we.push_back(iop == 2'd2);
                    exp_wd.push_back(iop == 2'd2 ? m_acc : 16'h0);
                    if (iop != 2'd2) opnd = mem[ea[7:0]];
                end
                if (iop == 2'd0) e_acc = opnd;
                if (iop == 2'd1) {e_carry, e_acc} = {1'b0, m_acc} + {1'b0, opnd};
                if (imd == 3'd6) e_ar = m_ar + 16'd1;
            end
        end
        d0 = ndone;
        @(negedge clk);
        start = 1'b1; op = iop; md = imd; rs = irs; cv = icv;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1; op = 2'd0; md = 3'd0; cv = 16'hFFFF;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, req, "done reached", done_o, 1);
        chk(illegal_o == ill, req, "illegal flag", illegal_o, ill);
        chk(acc_o == e_acc, req, "accumulator at done", acc_o, e_acc);
        chk(carry_o == e_carry, req, "carry at done", carry_o, e_carry);
        #2;
        chk(obs_addr.size() == exp_addr.size(), req, "memory access count",
            obs_addr.size(), exp_addr.size());
        if (obs_addr.size() == exp_addr.size()) begin
            for (int i = 0; i < exp_addr.size(); i++) begin
                chk(obs_addr[i] == exp_addr[i], req, "access address", obs_addr[i], exp_addr[i]);
                chk(obs_we[i] == exp_we[i], req, "access direction", obs_we[i], exp_we[i]);
                if (exp_we[i]) chk(obs_wd[i] == exp_wd[i], req, "write data", obs_wd[i], exp_wd[i]);
            end
        end
        chk(ndone == d0 + 1, "R2", "one done per instruction", ndone, d0 + 1);
        m_acc = e_acc; m_carry = e_carry; m_ar = e_ar;
        for (int i = 0; i < 4; i++) m_regs[i] = e_regs[i];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
        for (int i = 0; i < 4; i++) m_regs[i] = '0;
        mem[10] = 16'd20;
        mem[20] = 16'h1234;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !illegal_o && !mem_req_o, "R1", "control outputs in reset",
            {busy_o, done_o, illegal_o, mem_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_o == 0 && carry_o == 0, "R1", "accumulator and carry after reset",
            {acc_o, carry_o}, 0);
        // R1: zero general register and address register seen through addressing
        run(2'd0, 3'd3, 2'd2, 16'h0, "R6");
        run(2'd0, 3'd4, 2'd0, 16'd5, "R7");
        // R3 R10 immediate load and direct/indirect adds
        run(2'd0, 3'd0, 2'd0, 16'd5, "R3");
        run(2'd1, 3'd1, 2'd0, 16'd10, "R4");
        run(2'd1, 3'd2, 2'd0, 16'd10, "R5");
        // R13 moves, then register direct through the moved value
        run(2'd3, 3'd0, 2'd1, 16'h0, "R13");
        run(2'd0, 3'd0, 2'd0, 16'd30, "R3");
        run(2'd3, 3'd1, 2'd0, 16'h0, "R13");
        run(2'd0, 3'd3, 2'd1, 16'h0, "R6");
        // R7 displacement leaves address register alone
        run(2'd1, 3'd4, 2'd0, 16'd4, "R7");
        run(2'd0, 3'd4, 2'd0, 16'd0, "R7");
        // R8 index
        run(2'd0, 3'd0, 2'd0, 16'd2, "R3");
        run(2'd3, 3'd0, 2'd2, 16'h0, "R13");
        run(2'd1, 3'd5, 2'd2, 16'h0, "R8");
        run(2'd0, 3'd4, 2'd0, 16'd0, "R8");
        // R9 autoindex twice, then displacement 0 shows the advanced register
        run(2'd0, 3'd6, 2'd2, 16'h0, "R9");
        run(2'd1, 3'd6, 2'd2, 16'h0, "R9");
        run(2'd0, 3'd4, 2'd0, 16'd0, "R9");
        // R11 saves in several modes with readback
        run(2'd2, 3'd1, 2'd0, 16'd50, "R11");
        run(2'd0, 3'd1, 2'd0, 16'd50, "R11");
        run(2'd2, 3'd2, 2'd0, 16'd10, "R11");
        run(2'd0, 3'd1, 2'd0, 16'd20, "R11");
        run(2'd2, 3'd6, 2'd0, 16'h0, "R11");
        run(2'd0, 3'd4, 2'd0, 16'd0, "R9");
        // R10 carry behaviour
        run(2'd0, 3'd0, 2'd0, 16'hFFF0, "R10");
        run(2'd1, 3'd0, 2'd0, 16'h0020, "R10");
        run(2'd0, 3'd0, 2'd0, 16'h0001, "R10");
        run(2'd1, 3'd0, 2'd0, 16'h0001, "R10");
        // R12 illegal combinations
        run(2'd2, 3'd0, 2'd0, 16'd40, "R12");
        run(2'd0, 3'd7, 2'd0, 16'd40, "R12");
        run(2'd3, 3'd3, 2'd1, 16'd40, "R12");
        run(2'd0, 3'd3, 2'd1, 16'h0, "R12");
        // R14 stalled memory, indirect read and indirect save
        lat = 2;
        run(2'd1, 3'd2, 2'd0, 16'd10, "R14");
        run(2'd2, 3'd2, 2'd0, 16'd10, "R14");
        run(2'd0, 3'd1, 2'd0, 16'd20, "R14");
        // R2 start raised while busy is ignored
        lat = 3;
        run(2'd1, 3'd1, 2'd0, 16'd7, "R2", 1'b1);
        lat = 0;
        run(2'd0, 3'd0, 2'd0, 16'd9, "R2");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule